// File: doc/BRIEF.md
# Table-Driven Register Auto-Loader

The block walks a table of initialization records held in a byte-readable memory and turns each record into a single register write. It runs after reset, when a start pulse arrives while it is idle and an auto-load enable input is set. If the enable is clear, it reports completion at once and issues no traffic, so the registers keep their reset defaults.

Each record occupies 16 bytes, and records follow one another with no gaps, starting at a table base address. The first word of a record holds the destination address, the second holds control bits and the third holds the write data. The fourth word is never read. Every field is big-endian. The engine fetches twelve bytes one at a time, then places the chosen bytes of the data word on the lanes that the destination address selects. It drives one write beat and waits until the register side accepts it. An in-band flag ends the walk. A record-count limit stops a table that has no end flag.

Top module: `tbl_loader`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done`, `error`, `rdReq` and `wrValid` are all 0 until a start is accepted.
- R2: A start while idle with `autoLoadEn` at 0 sets `done` in the next cycle. No byte read and no write follow.
- R3: Record k is read as twelve byte requests at `tableBase + 16*k + 0` up to `+ 11`, in increasing order. A byte is taken only in a cycle where `rdReq` and `rdValid` are both 1, and `rdAddr` holds its value until then.
- R4: Bytes 0 to 3 of a record form the destination address, with byte 0 as the most significant. Bytes 8 to 11 form the data word the same way. In byte 7 only bits 2 to 0 matter. Bytes 4 to 6 and bits 7 to 3 of byte 7 have no effect on the write.
- R5: Bits 1:0 of byte 7 give the write size: 0 means 4 bytes, 1 means 1 byte, 2 means 2 bytes, 3 means 3 bytes.
- R6: With lane offset o = destination bits 1:0 and size n, the write carries `wrAddr` = destination with bits 1:0 cleared, `wrData` = data word shifted right by 8*o, and `wrStrb` bits o up to o+n-1 set. Strobe bit i marks the byte at offset i in the word and travels on `wrData[31-8i -: 8]`.
- R7: A record whose o + n exceeds 4 issues no write and sets `error`. The walk then goes on with the next record.
- R8: Bit 2 of byte 7 marks the last record. After that record is handled, `busy` falls and `done` rises.
- R9: `wrAddr`, `wrData` and `wrStrb` stay steady while `wrValid` is 1 and `wrReady` is 0. No byte read is requested while a write is pending.
- R10: With the limit MAX_RECORDS, a table without a last flag stops after MAX_RECORDS records. `busy` falls, `error` is 1 and `done` stays 0.
- R11: A start while `busy` is 1 is ignored. The current walk continues unchanged.
- R12: `busy` is 1 from the cycle after an accepted start until the walk ends. An accepted start clears `done` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| autoLoadEn | input | 1 | Enables table walking when a start is taken |
| tableBase | input | 32 | Byte address of the first record |
| start | input | 1 | Begins a walk when idle |
| rdReq | output | 1 | Byte read request |
| rdAddr | output | 32 | Byte address being requested |
| rdValid | input | 1 | Read data valid for the current request |
| rdData | input | 8 | Read data byte |
| wrValid | output | 1 | Write beat valid |
| wrAddr | output | 32 | Word-aligned write address |
| wrData | output | 32 | Write data, lane i on bits 31-8i down to 24-8i |
| wrStrb | output | 4 | Byte strobes, bit i for byte offset i |
| wrReady | input | 1 | Write accepted when high with wrValid |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished normally |
| error | output | 1 | Skipped crossing write or record limit reached |

## Verification
The bench targets lane placement at every offset with every size, including sizes that end exactly on the word boundary and one that crosses it. A design that numbered lanes little-endian, or took the low bytes of the data word instead of the high ones, would put data on the wrong strobes. A reserved-bits-all-ones control word exposes decoding that leaks into the size or last bits. A first-record last flag and a flagless table show whether the engine stops one record early or late, or reports the wrong completion output. Slow read responses, back-pressured writes and a start pulse in mid-walk catch an engine that samples unaccepted bytes, drops a held write or restarts itself.

// File: rtl/tbl_loader_pkg.sv
package tbl_loader_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int LANES      = WORD_W / BYTE_W;
  localparam int LANE_W     = $clog2(LANES);
  localparam int FIELD_W    = 32;
  localparam int REC_BYTES  = 12;
  localparam int REC_STRIDE = 16;
  localparam int IDX_W      = $clog2(REC_STRIDE);
  localparam int FIELD_BYTES = FIELD_W / BYTE_W;
  localparam int CTRL_TAIL  = 2 * FIELD_BYTES - 1;
  localparam int DATA_HEAD  = 2 * FIELD_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } ldState_t;

  typedef struct packed {
    logic loadBase;
    logic takeByte;
    logic nextRec;
  } dpCtrl_t;
endpackage

// File: rtl/tbl_loader_dp.sv
module tbl_loader_dp
  import tbl_loader_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_RECORDS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [ADDR_W-1:0]   tableBase,
  input  logic [BYTE_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [WORD_W-1:0]   wrData,
  output logic [LANES-1:0]    wrStrb,
  output logic                lastByte,
  output logic                recLast,
  output logic                recCross,
  output logic                atLimit
);
  localparam int CNT_W = (MAX_RECORDS > 1) ? $clog2(MAX_RECORDS) : 1;
  localparam int SH_W  = LANE_W + $clog2(BYTE_W);

  logic [ADDR_W-1:0]  recBase;
  logic [IDX_W-1:0]   byteIdx;
  logic [CNT_W-1:0]   recCount;
  logic [FIELD_W-1:0] destField;
  logic [WORD_W-1:0]  dataWord;
  logic [LANE_W:0]    ctrlBits;
  logic [LANE_W-1:0]  sizeCode;
  logic [LANE_W-1:0]  laneOff;
  logic [LANE_W:0]    byteCount;
  logic [LANE_W:0]    endLane;
  logic [SH_W-1:0]    shAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recBase   <= '0;
      byteIdx   <= '0;
      recCount  <= '0;
      destField <= '0;
      dataWord  <= '0;
      ctrlBits  <= '0;
    end else if (ctrl.loadBase) begin
      recBase  <= tableBase;
      byteIdx  <= '0;
      recCount <= '0;
    end else begin
      if (ctrl.takeByte) begin
        byteIdx <= byteIdx + 1'b1;
        if (byteIdx < IDX_W'(FIELD_BYTES))
          destField <= {destField[FIELD_W-BYTE_W-1:0], rdData};
        if (byteIdx == IDX_W'(CTRL_TAIL))
          ctrlBits <= rdData[LANE_W:0];
        if (byteIdx >= IDX_W'(DATA_HEAD))
          dataWord <= {dataWord[WORD_W-BYTE_W-1:0], rdData};
      end
      if (ctrl.nextRec) begin
        recBase  <= recBase + ADDR_W'(REC_STRIDE);
        byteIdx  <= '0;
        recCount <= recCount + 1'b1;
      end
    end
  end

  assign rdAddr   = recBase + ADDR_W'(byteIdx);
  assign lastByte = (byteIdx == IDX_W'(REC_BYTES - 1));
  assign atLimit  = (recCount == CNT_W'(MAX_RECORDS - 1));

  assign sizeCode  = ctrlBits[LANE_W-1:0];
  assign recLast   = ctrlBits[LANE_W];
  assign laneOff   = destField[LANE_W-1:0];
  assign byteCount = (sizeCode == '0) ? (LANE_W+1)'(LANES) : {1'b0, sizeCode};
  assign endLane   = {1'b0, laneOff} + byteCount;
  assign recCross  = (endLane > (LANE_W+1)'(LANES));

  assign shAmt  = {laneOff, {(SH_W-LANE_W){1'b0}}};
  assign wrData = dataWord >> shAmt;
  assign wrAddr = {destField[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrStrb[g] = ((LANE_W+1)'(g) >= {1'b0, laneOff}) &&
                       ((LANE_W+1)'(g) < endLane);
  end
endmodule

// File: rtl/tbl_loader_ctl.sv
module tbl_loader_ctl
  import tbl_loader_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    autoLoadEn,
  input  logic    rdValid,
  input  logic    wrReady,
  input  logic    lastByte,
  input  logic    recLast,
  input  logic    recCross,
  input  logic    atLimit,
  output dpCtrl_t ctrl,
  output logic    rdReq,
  output logic    wrValid,
  output logic    busy,
  output logic    done,
  output logic    error
);
  ldState_t state, stateNext;
  logic startTaken;
  logic recDone;

  assign startTaken = (state == ST_IDLE) && start;
  assign rdReq      = (state == ST_FETCH);
  assign wrValid    = (state == ST_WRITE) && !recCross;
  assign recDone    = (state == ST_WRITE) && (recCross || wrReady);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    ctrl          = '0;
    ctrl.loadBase = startTaken && autoLoadEn;
    ctrl.takeByte = rdReq && rdValid;
    ctrl.nextRec  = recDone && !recLast && !atLimit;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startTaken && autoLoadEn) stateNext = ST_FETCH;
      ST_FETCH: if (ctrl.takeByte && lastByte) stateNext = ST_WRITE;
      ST_WRITE: if (recDone) stateNext = (recLast || atLimit) ? ST_IDLE : ST_FETCH;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= stateNext;
      if (startTaken) begin
        done  <= !autoLoadEn;
        error <= 1'b0;
      end
      if (recDone && recCross) error <= 1'b1;
      if (recDone && recLast) done <= 1'b1;
      else if (recDone && atLimit) error <= 1'b1;
    end
  end
endmodule

// File: rtl/tbl_loader.sv
module tbl_loader
  import tbl_loader_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_RECORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoLoadEn,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic              start,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [3:0]        wrStrb,
  input  logic              wrReady,
  output logic              busy,
  output logic              done,
  output logic              error
);
  dpCtrl_t dpCtrl;
  logic lastByte, recLast, recCross, atLimit;

  tbl_loader_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .autoLoadEn (autoLoadEn),
    .rdValid    (rdValid),
    .wrReady    (wrReady),
    .lastByte   (lastByte),
    .recLast    (recLast),
    .recCross   (recCross),
    .atLimit    (atLimit),
    .ctrl       (dpCtrl),
    .rdReq      (rdReq),
    .wrValid    (wrValid),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  tbl_loader_dp #(
    .ADDR_W      (ADDR_W),
    .MAX_RECORDS (MAX_RECORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .tableBase (tableBase),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrStrb    (wrStrb),
    .lastByte  (lastByte),
    .recLast   (recLast),
    .recCross  (recCross),
    .atLimit   (atLimit)
  );
endmodule

// File: rtl/tbl_loader_chk.sv
module tbl_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [3:0]        wrStrb,
  input logic              wrReady,
  input logic              busy,
  input logic              done
);
  logic [3:0] lowBit;
  logic [3:0] runSum;
  assign lowBit = wrStrb & (~wrStrb + 4'd1);
  assign runSum = wrStrb + lowBit;

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrStrb)));

  assert_no_rd_during_wr_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !rdReq);

  assert_strb_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrStrb != 4'd0));

  assert_strb_contig_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ((runSum & wrStrb) == 4'd0));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_traffic_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || wrValid) |-> busy);
endmodule

bind tbl_loader tbl_loader_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/tbl_loader_test.sv
module tbl_loader_test;
  localparam int MAXREC = 16;

  typedef struct packed {
    logic [31:0] dest;
    logic [31:0] ctl;
    logic [31:0] data;
    logic [31:0] eAddr;
    logic [31:0] eData;
    logic [3:0]  eStrb;
    logic        eWr;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h40000000, 32'h00000000, 32'hA1B2C3D4, 32'h40000000, 32'hA1B2C3D4, 4'b1111, 1'b1},
    '{32'h40000005, 32'h00000001, 32'h5E6F7081, 32'h40000004, 32'h005E6F70, 4'b0010, 1'b1},
    '{32'h4000000A, 32'h00000002, 32'h12345678, 32'h40000008, 32'h00001234, 4'b1100, 1'b1},
    '{32'h4000000D, 32'h00000003, 32'hCAFEBABE, 32'h4000000C, 32'h00CAFEBA, 4'b1110, 1'b1},
    '{32'h40000013, 32'h00000001, 32'h99887766, 32'h40000010, 32'h00000099, 4'b1000, 1'b1},
    '{32'h40000017, 32'h00000002, 32'h11223344, 32'h0,        32'h0,        4'b0000, 1'b0},
    '{32'h40000020, 32'hFFFFFFF8, 32'h0BADF00D, 32'h40000020, 32'h0BADF00D, 4'b1111, 1'b1},
    '{32'h40000031, 32'h00000006, 32'h7654ABCD, 32'h40000030, 32'h007654AB, 4'b0110, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        autoLoadEn = 1'b0;
  logic [31:0] tableBase = '0;
  logic        start = 1'b0;
  logic        rdReq, wrValid, busy, done, error;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [3:0]  wrStrb;
  logic        rdValid = 1'b0;
  logic [7:0]  rdData = '0;
  logic        wrReady = 1'b0;

  logic        slowRead = 1'b0;
  logic        stallWr = 1'b0;
  logic [31:0] cyc = '0;
  logic [7:0]  mem [0:511];

  int checks = 0;
  int errors = 0;
  int rdCnt = 0, rdErr = 0, rdSeqBase = 0;
  int wrCnt = 0, holdErr = 0, overlapErr = 0, stallSeen = 0;
  logic [31:0] logAddr [0:31];
  logic [31:0] logData [0:31];
  logic [3:0]  logStrb [0:31];
  logic        prevPend = 1'b0;
  logic [31:0] prevAddr, prevData;
  logic [3:0]  prevStrb;

  always #2 clk = ~clk;

  tbl_loader #(.ADDR_W(32), .MAX_RECORDS(MAXREC)) uut (
    .clk(clk), .rstN(rstN), .autoLoadEn(autoLoadEn), .tableBase(tableBase),
    .start(start), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrb(wrStrb), .wrReady(wrReady), .busy(busy), .done(done), .error(error)
  );

  // memory and register-side models
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rdValid <= rdReq && !rdValid && (!slowRead || cyc[0]);
    rdData  <= mem[rdAddr[8:0]];
    wrReady <= !stallWr || (cyc % 3 == 0);
  end

  // monitors
  always @(posedge clk) begin
    if (rdReq && rdValid) begin
      if (rdAddr != 32'(rdSeqBase + 16 * (rdCnt / 12) + (rdCnt % 12))) rdErr++;
      rdCnt++;
    end
    if (rdReq && wrValid) overlapErr++;
    if (prevPend && !(wrValid && wrAddr == prevAddr && wrData == prevData && wrStrb == prevStrb))
      holdErr++;
    if (wrValid && !wrReady) stallSeen++;
    prevPend <= wrValid && !wrReady;
    prevAddr <= wrAddr;
    prevData <= wrData;
    prevStrb <= wrStrb;
    if (wrValid && wrReady) begin
      if (wrCnt < 32) begin
        logAddr[wrCnt] = wrAddr;
        logData[wrCnt] = wrData;
        logStrb[wrCnt] = wrStrb;
      end
      wrCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic putRec(input int base, input int k, input logic [31:0] dest,
                        input logic [31:0] ctl, input logic [31:0] data);
    int a;
    a = base + 16 * k;
    for (int b = 0; b < 4; b++) begin
      mem[a + b]      = dest[31 - 8*b -: 8];
      mem[a + 4 + b]  = ctl[31 - 8*b -: 8];
      mem[a + 8 + b]  = data[31 - 8*b -: 8];
      mem[a + 12 + b] = 8'hEE;
    end
  endtask

  task automatic clearMon(input int base);
    rdCnt = 0; rdErr = 0; rdSeqBase = base;
    wrCnt = 0; holdErr = 0; overlapErr = 0; stallSeen = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ei;
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;

    // R1: reset state
    repeat (4) @(negedge clk);
    check({busy, done, error, rdReq, wrValid} == 5'b0, "R1", "outputs in reset",
          32'({busy, done, error, rdReq, wrValid}), 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, error, rdReq, wrValid} == 5'b0, "R1", "outputs after reset",
          32'({busy, done, error, rdReq, wrValid}), 32'h0);

    // R2: disabled auto-load finishes at once
    clearMon(0);
    autoLoadEn = 1'b0;
    pulseStart();
    check(done && !busy, "R2", "done without walk", 32'({done, busy}), 32'h2);
    repeat (20) @(negedge clk);
    check(rdCnt == 0 && wrCnt == 0, "R2", "no traffic", 32'(rdCnt + wrCnt), 32'h0);

    // vector table walk: slow reads, stalled writes, stray start mid-walk
    for (int v = 0; v < NVEC; v++) putRec(16, v, VECS[v].dest, VECS[v].ctl, VECS[v].data);
    clearMon(16);
    autoLoadEn = 1'b1;
    tableBase = 32'h10;
    slowRead = 1'b1;
    stallWr = 1'b1;
    pulseStart();
    check(busy && !done && !error, "R12", "busy after start, flags cleared",
          32'({busy, done, error}), 32'h4);
    repeat (40) @(negedge clk);
    tableBase = 32'h100;   // R11: start while busy must be ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tableBase = 32'h10;
    waitIdle();
    ei = 0;
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].eWr) begin
        check(logAddr[ei] == VECS[v].eAddr, "R4/R6", $sformatf("vec %0d address", v),
              logAddr[ei], VECS[v].eAddr);
        check(logData[ei] == VECS[v].eData, "R4/R6", $sformatf("vec %0d data", v),
              logData[ei], VECS[v].eData);
        check(logStrb[ei] == VECS[v].eStrb, "R5/R6", $sformatf("vec %0d strobes", v),
              32'(logStrb[ei]), 32'(VECS[v].eStrb));
        ei++;
      end
    end
    check(wrCnt == 7, "R7", "crossing record skipped", 32'(wrCnt), 32'd7);
    check(error == 1'b1, "R7", "error after crossing", 32'(error), 32'h1);
    check(done && !busy, "R8", "done after last record", 32'({done, busy}), 32'h2);
    check(rdCnt == 96 && rdErr == 0, "R3", "read order", 32'(rdCnt + 1000 * rdErr), 32'd96);
    check(rdErr == 0 && wrCnt == 7, "R11", "stray start ignored", 32'(rdErr), 32'h0);
    check(holdErr == 0 && overlapErr == 0 && stallSeen > 0, "R9", "held write",
          32'(holdErr + overlapErr), 32'h0);

    // R8: last flag on the first record, flags cleared by new start
    putRec(256, 0, 32'h60000004, 32'h00000004, 32'hDEADBEEF);
    clearMon(256);
    tableBase = 32'h100;
    slowRead = 1'b0;
    stallWr = 1'b0;
    pulseStart();
    check(!done && !error && busy, "R12", "start clears done and error",
          32'({busy, done, error}), 32'h4);
    waitIdle();
    check(wrCnt == 1 && rdCnt == 12, "R8", "single record table", 32'(wrCnt), 32'h1);
    check(logAddr[0] == 32'h60000004 && logData[0] == 32'hDEADBEEF && logStrb[0] == 4'hF,
          "R8", "single record write", logData[0], 32'hDEADBEEF);
    check(done && !error, "R8", "done flag", 32'({done, error}), 32'h2);

    // R10: no last flag within the record limit
    for (int k = 0; k < MAXREC; k++) putRec(256, k, 32'h50000000 + 32'(4 * k), 32'h0, 32'(k));
    clearMon(256);
    pulseStart();
    waitIdle();
    check(wrCnt == MAXREC, "R10", "writes before limit", 32'(wrCnt), 32'(MAXREC));
    check(error && !done && !busy, "R10", "limit stop flags", 32'({error, done, busy}), 32'h4);
    check(logAddr[MAXREC-1] == 32'h50000000 + 32'(4 * (MAXREC-1)), "R10", "last write address",
          logAddr[MAXREC-1], 32'h50000000 + 32'(4 * (MAXREC-1)));
    check(rdCnt == 12 * MAXREC && rdErr == 0, "R3", "reads up to limit", 32'(rdCnt), 32'(12 * MAXREC));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule